// File: doc/BRIEF.md
# CPU Clock Switch Sequencer

This block moves a CPU clock domain safely across a change of its primary PLL rate. Before the PLL relocks, a pre-change request carries the old and new primary rates and the rate of an alternate source. The block finds the divider settings for the new rate in a small preloaded table. If the alternate source runs faster than the old rate, it works out a divider that holds the core clock at or below the old rate. It then moves the domain onto the alternate source and programs the dividers. After the relock, a post-change request moves the domain back to the primary source and puts the core divider back to divide-by-one.

The block drives a simple register port into a divider and mux bank. A read returns data in the same cycle, and a write takes effect at the clock edge. The block polls the bank's status registers after each change. Every poll has a timeout measured in clock cycles. A timeout raises a flag, and the sequence then carries on. Two build options are parameters: the second divider register (on by default) and holding the debug trace-bus divider at its slowest setting while on the alternate source (on by default). The requirements below assume both options are on.

Top module: `cpuclk_switch_seq`

## Requirements
- R1: A pre request (`reqPre`) or post request (`reqPost`) seen while idle is accepted at that clock edge; `reqPre` wins if both are high. `busy` is high from the next cycle through the cycle in which `done` pulses for one cycle, and is low after that. The flags `errInvalid`, `errTimeout` and `warnDiv` are cleared when a request is accepted and hold their value from `done` until the next acceptance.
- R2: A table entry matches when its rate in kHz times 1000 equals `newRateHz`. An entry of rate 0, or the end of the table, stops the search. A pre request that finds no match raises `errInvalid` with `done` and makes no bus write.
- R3: When `altRateHz` > `oldRateHz`, the safe divider is d = ceil(alt/old) − 1. It is written first as a read-modify-write of DIV0 (index 2): bits 2:0 take d, bits 18:16 take 3'b111, and all other bits keep their value. The block then polls DIV0-status (index 4) until bits 2:0 and 18:16 read zero. When alt ≤ old, no safe write is made.
- R4: If d would be 8 or more, `warnDiv` is raised and bits 2:0 are written as 7.
- R5: The move to the alternate source is a read-modify-write of SRC (index 0) that sets bit 16. The block then polls MUXSTAT (index 1) until bits 18:16 equal 2. This write comes after the safe-divider write.
- R6: Next, DIV0 is written with the table DIV0 value ORed with the safe bits of R3 (nothing when no safe write was made). The block polls DIV0-status until all its bits are zero. Then DIV1 (index 3) is written with the table value and the block polls DIV1-status (index 5) until it reads zero.
- R7: If SRC bit 20 is set, the DIV1 value written is the current DIV1 masked with 32'h77 (bits 6:4 and 2:0) instead of the table value.
- R8: A post request clears SRC bit 16 by read-modify-write and polls until MUXSTAT bits 18:16 equal 1. It then looks up the new rate and writes DIV0 by read-modify-write: bits 2:0 become 0, bits 18:16 are taken from the table entry, and all other bits keep their value. Last, it polls as in R3.
- R9: A poll that is not satisfied within TMO_MS × CYCLES_PER_MS cycles raises `errTimeout`, and the sequence goes on to its next step.
- R10: A request that arrives while `busy` is high pulses `errBusy` in the next cycle. It is not queued and causes no bus activity.
- R11: A post request whose new rate has no table entry still makes the SRC write of R8. It then raises `errInvalid` and makes no DIV0 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqPre | input | 1 | Pre-change request |
| reqPost | input | 1 | Post-change request |
| oldRateHz | input | 32 | Primary rate before the change, in Hz |
| newRateHz | input | 32 | Primary rate after the change, in Hz |
| altRateHz | input | 32 | Alternate source rate, in Hz |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| errInvalid | output | 1 | No table entry for the new rate |
| errTimeout | output | 1 | A status poll timed out |
| warnDiv | output | 1 | Safe divider was out of range and was clamped |
| errBusy | output | 1 | Pulse: a request was rejected while busy |
| busAddr | output | 3 | Register index in the bank |
| busWrEn | output | 1 | Write strobe |
| busWrData | output | 32 | Write data |
| busRdData | input | 32 | Read data, valid in the same cycle |

## Verification
The bench covers these corner cases:
- An alternate rate exactly twice the old rate. Here d must be 1, and a divider rounded the wrong way gives 0 or 2.
- An alternate rate ten times the old rate. Here d must be clamped to 7 with `warnDiv` raised. A design without the clamp would wrap the field to a low divide.
- The bit-20 source select. With it set, the current DIV1 fields must be written back, and a design that ignores it writes the table value.
- An unknown rate. On a pre request there must be no write at all. On a post request the SRC write must happen and the DIV0 write must not.
- A mux status that never settles. This must end in `errTimeout` and the remaining writes must still follow; a design that stalls hangs. A design that lets a write out of order, or drops the safe write, shows a mismatch against the expected write order.

// File: rtl/cpuclk_seq_pkg.sv
package cpuclk_seq_pkg;

  // register indices in the divider/mux bank
  localparam logic [2:0] REG_SRC    = 3'd0;
  localparam logic [2:0] REG_MUXST  = 3'd1;
  localparam logic [2:0] REG_DIV0   = 3'd2;
  localparam logic [2:0] REG_DIV1   = 3'd3;
  localparam logic [2:0] REG_DSTAT0 = 3'd4;
  localparam logic [2:0] REG_DSTAT1 = 3'd5;

  localparam int ALT_SEL_BIT = 16;
  localparam int HPM_SEL_BIT = 20;
  localparam int MUX_ST_LSB  = 16;

  localparam logic [31:0] CORE_FIELD  = 32'h0000_0007;
  localparam logic [31:0] TRACE_FIELD = 32'h0007_0000;
  localparam logic [31:0] DIV1_KEEP   = 32'h0000_0077;

  typedef enum logic [3:0] {
    BUS_NONE, BUS_RD_SRC, BUS_RD_DIV1, BUS_WR_SAFE, BUS_WR_ALT,
    BUS_WR_PRI, BUS_WR_FULL0, BUS_WR_FULL1, BUS_WR_REST
  } busOp_e;

  typedef enum logic [2:0] {
    WAIT_NONE, WAIT_MUX_ALT, WAIT_MUX_PRI, WAIT_DIV0_MASK,
    WAIT_DIV0_ALL, WAIT_DIV1_ALL
  } waitOp_e;

  typedef struct packed {
    logic    capture;
    logic    tblStep;
    logic    tblLoadPre;
    logic    tblLoadPost;
    logic    calcStep;
    logic    setInvalid;
    busOp_e  busOp;
    waitOp_e waitOp;
  } ctrlStrb_t;

  typedef struct packed {
    logic tblEnd;
    logic tblHit;
    logic altFaster;
    logic calcDone;
    logic waitDone;
  } dpStat_t;

endpackage

// File: rtl/cpuclk_seq_dp.sv
module cpuclk_seq_dp
  import cpuclk_seq_pkg::*;
#(
  parameter int TBL_DEPTH     = 4,
  parameter int CYCLES_PER_MS = 100000,
  parameter int TMO_MS        = 10,
  parameter bit DBG_ALT       = 1'b1,
  parameter logic [TBL_DEPTH*32-1:0] TBL_KHZ  = '0,
  parameter logic [TBL_DEPTH*32-1:0] TBL_DIV0 = '0,
  parameter logic [TBL_DEPTH*32-1:0] TBL_DIV1 = '0
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] oldRateHz,
  input  logic [31:0] newRateHz,
  input  logic [31:0] altRateHz,
  input  ctrlStrb_t   strb,
  output dpStat_t     stat,
  output logic [2:0]  busAddr,
  output logic        busWrEn,
  output logic [31:0] busWrData,
  input  logic [31:0] busRdData,
  output logic        errInvalid,
  output logic        errTimeout,
  output logic        warnDiv
);

  localparam int IDX_W      = $clog2(TBL_DEPTH + 1);
  localparam int ACC_W      = 36;
  localparam int TMO_CYCLES = CYCLES_PER_MS * TMO_MS;
  localparam int TMO_W      = $clog2(TMO_CYCLES + 1);
  localparam logic [31:0] SAFE_MASK = DBG_ALT ? (CORE_FIELD | TRACE_FIELD) : CORE_FIELD;
  localparam logic [31:0] SAFE_HIGH = DBG_ALT ? TRACE_FIELD : 32'h0;

  logic [31:0] oldR, newR, altR;
  logic [IDX_W-1:0] tblIdx;
  logic [31:0] entKhz, entDiv0, entDiv1;
  logic [31:0] div0Val, div1Val, restBits;
  logic        hpmSel;
  logic [3:0]  calcK;
  logic [ACC_W-1:0] calcAcc;
  logic [TMO_W-1:0] tmoCnt;
  logic        waitOk, tmoHit;
  logic [31:0] safeBits;

  // table entry selection, one comparator per entry
  always_comb begin
    entKhz  = '0;
    entDiv0 = '0;
    entDiv1 = '0;
    for (int i = 0; i < TBL_DEPTH; i++) begin
      if (tblIdx == IDX_W'(i)) begin
        entKhz  = TBL_KHZ[i*32 +: 32];
        entDiv0 = TBL_DIV0[i*32 +: 32];
        entDiv1 = TBL_DIV1[i*32 +: 32];
      end
    end
  end

  assign stat.tblEnd    = (entKhz == 32'd0);
  assign stat.tblHit    = (entKhz != 32'd0) && ((42'(entKhz) * 42'd1000) == 42'(newR));
  assign stat.altFaster = altR > oldR;
  assign stat.calcDone  = (calcAcc >= ACC_W'(altR)) || (calcK == 4'd8);

  assign safeBits = SAFE_HIGH | {29'd0, calcK[2:0] - 3'd1};

  // bus address and write data
  always_comb begin
    busAddr   = REG_SRC;
    busWrEn   = 1'b0;
    busWrData = '0;
    unique case (strb.busOp)
      BUS_RD_SRC:   busAddr = REG_SRC;
      BUS_RD_DIV1:  busAddr = REG_DIV1;
      BUS_WR_SAFE: begin
        busAddr   = REG_DIV0;
        busWrEn   = 1'b1;
        busWrData = (busRdData & ~SAFE_MASK) | (safeBits & SAFE_MASK);
      end
      BUS_WR_ALT: begin
        busAddr   = REG_SRC;
        busWrEn   = 1'b1;
        busWrData = busRdData | (32'd1 << ALT_SEL_BIT);
      end
      BUS_WR_PRI: begin
        busAddr   = REG_SRC;
        busWrEn   = 1'b1;
        busWrData = busRdData & ~(32'd1 << ALT_SEL_BIT);
      end
      BUS_WR_FULL0: begin
        busAddr   = REG_DIV0;
        busWrEn   = 1'b1;
        busWrData = div0Val;
      end
      BUS_WR_FULL1: begin
        busAddr   = REG_DIV1;
        busWrEn   = 1'b1;
        busWrData = div1Val;
      end
      BUS_WR_REST: begin
        busAddr   = REG_DIV0;
        busWrEn   = 1'b1;
        busWrData = (busRdData & ~SAFE_MASK) | restBits;
      end
      default: begin
        unique case (strb.waitOp)
          WAIT_MUX_ALT, WAIT_MUX_PRI:    busAddr = REG_MUXST;
          WAIT_DIV0_MASK, WAIT_DIV0_ALL: busAddr = REG_DSTAT0;
          WAIT_DIV1_ALL:                 busAddr = REG_DSTAT1;
          default:                       busAddr = REG_SRC;
        endcase
      end
    endcase
  end

  // poll evaluation
  always_comb begin
    unique case (strb.waitOp)
      WAIT_MUX_ALT:   waitOk = busRdData[MUX_ST_LSB +: 3] == 3'd2;
      WAIT_MUX_PRI:   waitOk = busRdData[MUX_ST_LSB +: 3] == 3'd1;
      WAIT_DIV0_MASK: waitOk = (busRdData & SAFE_MASK) == '0;
      WAIT_DIV0_ALL,
      WAIT_DIV1_ALL:  waitOk = busRdData == '0;
      default:        waitOk = 1'b0;
    endcase
  end

  assign tmoHit        = tmoCnt == TMO_W'(TMO_CYCLES - 1);
  assign stat.waitDone = waitOk || tmoHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oldR <= '0; newR <= '0; altR <= '0;
      tblIdx <= '0;
      div0Val <= '0; div1Val <= '0; restBits <= '0;
      hpmSel <= 1'b0;
      calcK <= 4'd1; calcAcc <= '0;
      tmoCnt <= '0;
      errInvalid <= 1'b0; errTimeout <= 1'b0; warnDiv <= 1'b0;
    end else begin
      if (strb.capture) begin
        oldR <= oldRateHz; newR <= newRateHz; altR <= altRateHz;
        tblIdx <= '0;
        restBits <= '0;
        hpmSel <= 1'b0;
        calcK <= 4'd1;
        calcAcc <= ACC_W'(oldRateHz);
        errInvalid <= 1'b0; errTimeout <= 1'b0; warnDiv <= 1'b0;
      end
      if (strb.tblStep) tblIdx <= tblIdx + 1'b1;
      if (strb.tblLoadPre) begin
        div0Val <= entDiv0;
        div1Val <= entDiv1;
      end
      if (strb.tblLoadPost) restBits <= entDiv0 & SAFE_HIGH;
      if (strb.calcStep) begin
        calcK   <= calcK + 4'd1;
        calcAcc <= calcAcc + ACC_W'(oldR);
      end
      if (strb.setInvalid) errInvalid <= 1'b1;
      if (strb.busOp == BUS_RD_SRC) hpmSel <= busRdData[HPM_SEL_BIT];
      if (strb.busOp == BUS_RD_DIV1 && hpmSel) div1Val <= busRdData & DIV1_KEEP;
      if (strb.busOp == BUS_WR_SAFE) begin
        div0Val <= div0Val | (safeBits & SAFE_MASK);
        if (calcAcc < ACC_W'(altR)) warnDiv <= 1'b1;
      end
      if (strb.waitOp == WAIT_NONE || stat.waitDone) tmoCnt <= '0;
      else tmoCnt <= tmoCnt + 1'b1;
      if (strb.waitOp != WAIT_NONE && !waitOk && tmoHit) errTimeout <= 1'b1;
    end
  end

endmodule

// File: rtl/cpuclk_seq_ctrl.sv
module cpuclk_seq_ctrl
  import cpuclk_seq_pkg::*;
#(
  parameter bit HAS_DIV1 = 1'b1,
  parameter bit DBG_ALT  = 1'b1
)(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqPre,
  input  logic      reqPost,
  input  dpStat_t   stat,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      done,
  output logic      errBusy
);

  typedef enum logic [4:0] {
    S_IDLE, S_LOOK, S_HPM, S_RDDIV1, S_CALC, S_SAFE, S_WSAFE,
    S_ALT, S_WALT, S_FULL0, S_WFULL0, S_FULL1, S_WFULL1,
    S_PRI, S_WPRI, S_PLOOK, S_REST, S_WREST, S_FIN
  } state_e;

  state_e state, nxt;

  assign busy = state != S_IDLE;
  assign done = state == S_FIN;

  always_comb begin
    strb = '{capture: 1'b0, tblStep: 1'b0, tblLoadPre: 1'b0, tblLoadPost: 1'b0,
             calcStep: 1'b0, setInvalid: 1'b0, busOp: BUS_NONE, waitOp: WAIT_NONE};
    nxt = state;
    unique case (state)
      S_IDLE: begin
        if (reqPre) begin
          strb.capture = 1'b1;
          nxt = S_LOOK;
        end else if (reqPost) begin
          strb.capture = 1'b1;
          nxt = S_PRI;
        end
      end
      S_LOOK: begin
        if (stat.tblEnd) begin
          strb.setInvalid = 1'b1;
          nxt = S_FIN;
        end else if (stat.tblHit) begin
          strb.tblLoadPre = 1'b1;
          if (HAS_DIV1)            nxt = S_HPM;
          else if (stat.altFaster) nxt = S_CALC;
          else                     nxt = S_ALT;
        end else begin
          strb.tblStep = 1'b1;
        end
      end
      S_HPM: begin
        strb.busOp = BUS_RD_SRC;
        nxt = S_RDDIV1;
      end
      S_RDDIV1: begin
        strb.busOp = BUS_RD_DIV1;
        nxt = stat.altFaster ? S_CALC : S_ALT;
      end
      S_CALC: begin
        if (stat.calcDone) nxt = S_SAFE;
        else strb.calcStep = 1'b1;
      end
      S_SAFE: begin
        strb.busOp = BUS_WR_SAFE;
        nxt = S_WSAFE;
      end
      S_WSAFE: begin
        strb.waitOp = WAIT_DIV0_MASK;
        if (stat.waitDone) nxt = S_ALT;
      end
      S_ALT: begin
        strb.busOp = BUS_WR_ALT;
        nxt = S_WALT;
      end
      S_WALT: begin
        strb.waitOp = WAIT_MUX_ALT;
        if (stat.waitDone) nxt = S_FULL0;
      end
      S_FULL0: begin
        strb.busOp = BUS_WR_FULL0;
        nxt = S_WFULL0;
      end
      S_WFULL0: begin
        strb.waitOp = WAIT_DIV0_ALL;
        if (stat.waitDone) nxt = HAS_DIV1 ? S_FULL1 : S_FIN;
      end
      S_FULL1: begin
        strb.busOp = BUS_WR_FULL1;
        nxt = S_WFULL1;
      end
      S_WFULL1: begin
        strb.waitOp = WAIT_DIV1_ALL;
        if (stat.waitDone) nxt = S_FIN;
      end
      S_PRI: begin
        strb.busOp = BUS_WR_PRI;
        nxt = S_WPRI;
      end
      S_WPRI: begin
        strb.waitOp = WAIT_MUX_PRI;
        if (stat.waitDone) nxt = DBG_ALT ? S_PLOOK : S_REST;
      end
      S_PLOOK: begin
        if (stat.tblEnd) begin
          strb.setInvalid = 1'b1;
          nxt = S_FIN;
        end else if (stat.tblHit) begin
          strb.tblLoadPost = 1'b1;
          nxt = S_REST;
        end else begin
          strb.tblStep = 1'b1;
        end
      end
      S_REST: begin
        strb.busOp = BUS_WR_REST;
        nxt = S_WREST;
      end
      S_WREST: begin
        strb.waitOp = WAIT_DIV0_MASK;
        if (stat.waitDone) nxt = S_FIN;
      end
      S_FIN: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      errBusy <= 1'b0;
    end else begin
      state   <= nxt;
      errBusy <= busy && (reqPre || reqPost);
    end
  end

endmodule

// File: rtl/cpuclk_switch_seq.sv
module cpuclk_switch_seq
  import cpuclk_seq_pkg::*;
#(
  parameter int TBL_DEPTH     = 4,
  parameter int CYCLES_PER_MS = 100000,
  parameter int TMO_MS        = 10,
  parameter bit HAS_DIV1      = 1'b1,
  parameter bit DBG_ALT       = 1'b1,
  parameter logic [TBL_DEPTH*32-1:0] TBL_KHZ  = {32'd0, 32'd400000, 32'd800000, 32'd1200000},
  parameter logic [TBL_DEPTH*32-1:0] TBL_DIV0 = {32'h0, 32'h0121_1300, 32'h0143_2600, 32'h0175_3700},
  parameter logic [TBL_DEPTH*32-1:0] TBL_DIV1 = {32'h0, 32'h13, 32'h24, 32'h35}
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqPre,
  input  logic        reqPost,
  input  logic [31:0] oldRateHz,
  input  logic [31:0] newRateHz,
  input  logic [31:0] altRateHz,
  output logic        busy,
  output logic        done,
  output logic        errInvalid,
  output logic        errTimeout,
  output logic        warnDiv,
  output logic        errBusy,
  output logic [2:0]  busAddr,
  output logic        busWrEn,
  output logic [31:0] busWrData,
  input  logic [31:0] busRdData
);

  ctrlStrb_t strb;
  dpStat_t   stat;

  cpuclk_seq_ctrl #(.HAS_DIV1(HAS_DIV1), .DBG_ALT(DBG_ALT)) uCtrl (
    .clk(clk), .rstN(rstN), .reqPre(reqPre), .reqPost(reqPost),
    .stat(stat), .strb(strb), .busy(busy), .done(done), .errBusy(errBusy)
  );

  cpuclk_seq_dp #(
    .TBL_DEPTH(TBL_DEPTH), .CYCLES_PER_MS(CYCLES_PER_MS), .TMO_MS(TMO_MS),
    .DBG_ALT(DBG_ALT), .TBL_KHZ(TBL_KHZ), .TBL_DIV0(TBL_DIV0), .TBL_DIV1(TBL_DIV1)
  ) uDp (
    .clk(clk), .rstN(rstN), .oldRateHz(oldRateHz), .newRateHz(newRateHz),
    .altRateHz(altRateHz), .strb(strb), .stat(stat), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .errInvalid(errInvalid), .errTimeout(errTimeout), .warnDiv(warnDiv)
  );

endmodule

// File: rtl/cpuclk_seq_chk.sv
module cpuclk_seq_chk (
  input logic clk,
  input logic rstN,
  input logic reqPre,
  input logic reqPost,
  input logic busy,
  input logic done,
  input logic errBusy,
  input logic errTimeout,
  input logic busWrEn
);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (reqPre || reqPost)) |=> busy);

  // R1
  done_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy ##1 !busy);

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqPre || reqPost));

  // R10
  reject_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (reqPre || reqPost)) |=> errBusy);

  // R10
  reject_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    errBusy |-> $past(busy));

  // R5
  write_in_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |-> busy);

  // R9
  timeout_in_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errTimeout) |-> busy);

endmodule

bind cpuclk_switch_seq cpuclk_seq_chk uChk (.*);

// File: tb/tb_cpuclk_switch_seq.sv
module tb_cpuclk_switch_seq;

  localparam int CPM = 10;
  localparam int TMO = CPM * 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqPre = 1'b0, reqPost = 1'b0;
  logic [31:0] oldRateHz = '0, newRateHz = '0, altRateHz = '0;
  logic busy, done, errInvalid, errTimeout, warnDiv, errBusy;
  logic [2:0] busAddr;
  logic busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;

  always #5 clk = ~clk;

  longint tKhz[4] = '{1200000, 800000, 400000, 0};
  logic [31:0] tD0[4] = '{32'h0175_3700, 32'h0143_2600, 32'h0121_1300, 32'h0};
  logic [31:0] tD1[4] = '{32'h35, 32'h24, 32'h13, 32'h0};

  cpuclk_switch_seq #(
    .TBL_DEPTH(4), .CYCLES_PER_MS(CPM), .TMO_MS(10), .HAS_DIV1(1'b1), .DBG_ALT(1'b1),
    .TBL_KHZ({32'd0, 32'd400000, 32'd800000, 32'd1200000}),
    .TBL_DIV0({32'h0, 32'h0121_1300, 32'h0143_2600, 32'h0175_3700}),
    .TBL_DIV1({32'h0, 32'h13, 32'h24, 32'h35})
  ) dut (.*);

  // behavioural divider/mux bank
  logic [31:0] rSrc, rDiv0, rDiv1;
  int muxBusy, d0Busy, d1Busy;
  bit stuckMux = 0;
  bit cfgLoad = 0, cfgHpm = 0;
  logic [2:0] muxSt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rSrc <= '0; rDiv0 <= '0; rDiv1 <= '0;
      muxBusy <= 0; d0Busy <= 0; d1Busy <= 0;
    end else begin
      if (muxBusy > 0) muxBusy <= muxBusy - 1;
      if (d0Busy > 0) d0Busy <= d0Busy - 1;
      if (d1Busy > 0) d1Busy <= d1Busy - 1;
      if (cfgLoad) rSrc[20] <= cfgHpm;
      if (busWrEn) begin
        case (busAddr)
          3'd0: begin
            if (busWrData[16] != rSrc[16]) muxBusy <= 3;
            rSrc <= busWrData;
          end
          3'd2: begin rDiv0 <= busWrData; d0Busy <= 2; end
          3'd3: begin rDiv1 <= busWrData; d1Busy <= 2; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    muxSt = (stuckMux || muxBusy > 0) ? 3'd4 : (rSrc[16] ? 3'd2 : 3'd1);
    case (busAddr)
      3'd0: busRdData = rSrc;
      3'd1: busRdData = {13'd0, muxSt, 16'd0};
      3'd2: busRdData = rDiv0;
      3'd3: busRdData = rDiv1;
      3'd4: busRdData = (d0Busy > 0) ? 32'h0001_0001 : 32'h0;
      3'd5: busRdData = (d1Busy > 0) ? 32'h1 : 32'h0;
      default: busRdData = '0;
    endcase
  end

  int nChk = 0, nFail = 0;
  int expA[$];
  logic [31:0] expD[$];
  string expR[$];

  task automatic chk(string req, string what, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(int a, logic [31:0] d, string r);
    expA.push_back(a); expD.push_back(d); expR.push_back(r);
  endtask

  // compare every bus write against the expected order
  always @(negedge clk) begin
    if (rstN && busWrEn) begin
      if (expA.size() == 0) begin
        chk("R10", "unexpected write", busAddr, 7);
      end else begin
        automatic int a = expA.pop_front();
        automatic logic [31:0] d = expD.pop_front();
        automatic string r = expR.pop_front();
        chk(r, "write index", busAddr, a);
        chk(r, "write data", busWrData, d);
      end
    end
  end

  function automatic int findIdx(longint hz);
    for (int i = 0; i < 4; i++) begin
      if (tKhz[i] == 0) return -1;
      if (tKhz[i] * 1000 == hz) return i;
    end
    return -1;
  endfunction

  task automatic runSeq(bit isPre, longint oldHz, longint newHz, longint altHz,
                        bit probe, bit expTmo, string tag);
    int idx;
    bit expInv = 0, expWarn = 0;
    logic [31:0] d0, d1, sb;
    longint sd;
    int cyc;
    idx = findIdx(newHz);
    if (isPre) begin
      if (idx < 0) expInv = 1;  // R2
      else begin
        d0 = tD0[idx];
        d1 = rSrc[20] ? (rDiv1 & 32'h77) : tD1[idx];  // R7
        if (altHz > oldHz) begin
          sd = (altHz + oldHz - 1) / oldHz - 1;         // R3
          if (sd >= 8) begin expWarn = 1; sd = 7; end   // R4
          sb = 32'h0007_0000 | 32'(sd);
          push(2, (rDiv0 & ~32'h0007_0007) | sb, "R3");
          d0 = d0 | sb;
        end
        push(0, rSrc | 32'h0001_0000, "R5");
        push(2, d0, "R6");
        push(3, d1, rSrc[20] ? "R7" : "R6");
      end
    end else begin
      push(0, rSrc & ~32'h0001_0000, "R8");
      if (idx < 0) expInv = 1;  // R11
      else push(2, (rDiv0 & ~32'h0007_0007) | (tD0[idx] & 32'h0007_0000), "R8");
    end
    oldRateHz = 32'(oldHz); newRateHz = 32'(newHz); altRateHz = 32'(altHz);
    reqPre = isPre; reqPost = !isPre;
    @(negedge clk);
    reqPre = 0; reqPost = 0;
    chk("R1", {tag, " busy after accept"}, busy, 1);
    chk("R1", {tag, " flags cleared"}, {errInvalid, errTimeout, warnDiv}, 0);
    if (probe) begin
      reqPost = 1;  // R10 reject while busy
      @(negedge clk);
      reqPost = 0;
      chk("R10", {tag, " errBusy"}, errBusy, 1);
      @(negedge clk);
      chk("R10", {tag, " errBusy one cycle"}, errBusy, 0);
    end
    cyc = 0;
    while (!done && cyc < 2000) begin
      if (!busy) chk("R1", {tag, " busy held"}, busy, 1);
      @(negedge clk);
      cyc++;
    end
    chk("R1", {tag, " done seen"}, done, 1);
    chk(isPre ? "R2" : "R11", {tag, " errInvalid"}, errInvalid, expInv);
    chk("R9", {tag, " errTimeout"}, errTimeout, expTmo);
    chk("R4", {tag, " warnDiv"}, warnDiv, expWarn);
    if (expTmo) chk("R9", {tag, " wait length"}, cyc >= TMO, 1);
    @(negedge clk);
    chk("R1", {tag, " idle after done"}, busy, 0);
    chk("R1", {tag, " flags hold"}, errInvalid, expInv);
    chk(isPre ? "R6" : "R8", {tag, " all writes seen"}, expA.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", wd);
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset done", done, 0);
    chk("R5", "reset write", busWrEn, 0);
    rstN = 1;
    @(negedge clk);
    // not faster alternate, no safe write
    runSeq(1, 800_000_000, 1_200_000_000, 800_000_000, 0, 0, "preA");
    runSeq(0, 0, 1_200_000_000, 0, 0, 0, "postA");
    // bit 20 set, safe divider 2, with busy reject probe
    cfgHpm = 1; cfgLoad = 1; @(negedge clk); cfgLoad = 0; @(negedge clk);
    runSeq(1, 400_000_000, 800_000_000, 1_000_000_000, 1, 0, "preB");
    runSeq(0, 0, 800_000_000, 0, 0, 0, "postB");
    cfgHpm = 0; cfgLoad = 1; @(negedge clk); cfgLoad = 0; @(negedge clk);
    // exact ratio two gives divider 1
    runSeq(1, 400_000_000, 400_000_000, 800_000_000, 0, 0, "preExact");
    runSeq(0, 0, 400_000_000, 0, 0, 0, "postExact");
    // out of range divider clamps
    runSeq(1, 100_000_000, 1_200_000_000, 1_000_000_000, 0, 0, "preClamp");
    runSeq(0, 0, 1_200_000_000, 0, 0, 0, "postClamp");
    // unknown rates
    runSeq(1, 800_000_000, 500_000_000, 800_000_000, 0, 0, "preBad");
    runSeq(0, 0, 500_000_000, 0, 0, 0, "postBad");
    // stuck mux status
    stuckMux = 1;
    runSeq(1, 800_000_000, 800_000_000, 400_000_000, 0, 1, "preTmo");
    stuckMux = 0;
    runSeq(0, 0, 800_000_000, 0, 0, 0, "postTmo");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule